// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Idle and Break Frames

This block serializes characters onto a single output line. Each character is framed by a low start bit, sent least significant bit first, and closed by one or two high stop bits. Optionally, a parity bit takes the place of the top data bit. Three character sizes are available. Bit timing comes from an external one-cycle baud tick, and every bit on the line lasts exactly one tick period.

Software-style writes arrive on a single write port. The `wr_sel` input chooses between the control word and the data word. Data is buffered in one of two ways:
- a single holding register, or
- a small FIFO whose depth is a parameter.

Besides characters, the block can send two special frames:
- an all-high idle frame, which goes out automatically whenever transmission is switched on;
- an all-low break frame, requested through a self-clearing control bit.

Three status outputs report buffer space and completion of the last frame.

Top module: `serial_tx`

## Requirements
- R1: After reset the line is high and `st_txe`, `st_txfnf` and `st_tc` are all 1. The control word resets to zero: block off, 8 data bits, one stop bit, no parity, holding-register mode.
- R2: A character frame has the following layout.
  - Word-length control bits [3:2]: code 00 gives 8 data bits, 01 gives 9, 10 gives 7, and 11 behaves as 00.
  - Control bit 4 selects two stop bits when set and one when clear.
  - The frame is a 0 start bit, then the data bits from bit 0 upward, then the high stop bits.
  - The line changes only on the clock edge where `baud_tick` is 1, so each bit lasts one tick period.
- R3: When control bit 5 is set, the last data position carries a parity bit computed over the lower data bits. Control bit 6 selects the parity sense: 0 makes the count of ones even, 1 makes it odd. The frame length does not change.
- R4: A control write that turns on transmit enable (bit 1) with the block enabled (bit 0) queues an idle frame. This includes a write that sets both bits together. The idle frame holds the line high for 1 + data bits + stop bits periods and goes out before any character or break.
- R5: Writing control bit 8 with the block enabled requests a break. The bit is not stored, and each write requests one break.
  - The break frame is data-bits + 2 low periods followed by two high periods: 10, 11 or 9 lows for codes 00, 01 and 10.
  - The break starts only after the frame in progress has ended.
  - The break goes out ahead of any pending data.
- R6: In holding-register mode (control bit 7 clear), a data write (`wr_sel`=1) clears `st_txe`. The flag sets again when the character moves into the shifter. A second write before that overwrites the first. `st_txfnf` follows `st_txe`.
- R7: In FIFO mode (control bit 7 set), each data write pushes one entry. `st_txfnf` is 0 exactly when the FIFO holds `FIFO_DEPTH` entries, and a write in that state is dropped. `st_txe` is 1 exactly when the FIFO is empty. Entries leave in write order.
- R8: `st_tc` is 0 while any frame is pending or on the line. It returns to 1 on the tick that ends the last stop bit, when nothing else is waiting.
- R9: Enable bits gate transmission as follows.
  - With transmit enable clear, no new frame starts.
  - A control write that clears the block enable (bit 0) takes effect on the next clock. It aborts the frame in progress, forces the line high, discards all buffered data and pending idle and break requests, and leaves `st_txe`=1 and `st_tc`=1.
  - While the block is disabled, data writes are ignored.
- R10: Whenever no frame is being sent, the line is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_sel | input | 1 | 0 selects the control word, 1 selects the data word |
| wr_data | input | 9 | Write value |
| baud_tick | input | 1 | One-cycle pulse per bit period |
| txd | output | 1 | Serial output line, idle high |
| st_txe | output | 1 | Buffer empty flag |
| st_txfnf | output | 1 | Buffer not full flag |
| st_tc | output | 1 | Transmission complete flag |

## Verification
The bench builds the block with `FIFO_DEPTH` = 4. This depth makes the full condition, the dropped fifth write and the drain order reachable within a few frames. The bench checks every cycle against a queue-based model. Ticks arrive both on a fixed four-cycle period and at random intervals, so back-to-back loads, simultaneous push and pop, and control writes in the middle of a frame all occur. Directed sequences capture whole frames bit by bit to confirm parity, break length and break-over-data priority.

// File: rtl/stx_pkg.sv
// Shared definitions for the serial transmitter: control word layout,
// frame kinds and the word-length decode. Assumes at most 9 data bits.
package stx_pkg;

    localparam int STX_MAX_BITS = 9;

    typedef enum logic [1:0] {
        FK_IDLE  = 2'd0,
        FK_BREAK = 2'd1,
        FK_DATA  = 2'd2
    } frame_kind_e;

    // Control word: bit 8 down to bit 0
    typedef struct packed {
        logic       brk;
        logic       fifo_en;
        logic       par_odd;
        logic       par_en;
        logic       two_stop;
        logic [1:0] wlen;
        logic       te;
        logic       ue;
    } ctrl_t;

    // Number of data bits for a word-length code (11 treated as 00)
    function automatic int data_bits(input logic [1:0] wl);
        case (wl)
            2'b01:   return 9;
            2'b10:   return 7;
            default: return 8;
        endcase
    endfunction

endpackage

// File: rtl/stx_ctrl.sv
// Control register and special-frame requests. Holds the configuration,
// latches the idle preamble and one-shot break requests, and picks the
// kind of the next frame (idle first, then break, then data).
// Assumes wr_ctrl and take may coincide; the write then wins.
module stx_ctrl
    import stx_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_ctrl,
    input  ctrl_t       wcfg,
    input  logic        take,
    output ctrl_t       cfg,
    output logic        pre_pend,
    output logic        brk_pend,
    output frame_kind_e kind
);

    // Configuration storage and request flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg      <= '0;
            pre_pend <= 1'b0;
            brk_pend <= 1'b0;
        end else begin
            if (take && pre_pend) begin
                pre_pend <= 1'b0;
            end else if (take && brk_pend) begin
                brk_pend <= 1'b0;
            end
            if (wr_ctrl) begin
                cfg     <= wcfg;
                cfg.brk <= 1'b0;
                if (!wcfg.ue) begin
                    pre_pend <= 1'b0;
                    brk_pend <= 1'b0;
                end else begin
                    if (wcfg.te && !(cfg.ue && cfg.te)) pre_pend <= 1'b1;
                    if (wcfg.brk) brk_pend <= 1'b1;
                end
            end
        end
    end

    // Frame-kind priority
    always_comb begin
        if (pre_pend)      kind = FK_IDLE;
        else if (brk_pend) kind = FK_BREAK;
        else               kind = FK_DATA;
    end

    p_break_one_shot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (take && kind == FK_BREAK && !wr_ctrl) |=> !brk_pend);

    p_cfg_brk_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctrl |=> !cfg.brk);

endmodule

// File: rtl/stx_buffer.sv
// Transmit data buffer: a single holding register or a DEPTH-entry FIFO,
// chosen by fifo_en. Produces the empty / not-full flags for the active
// buffer. Assumes the mode changes only while both buffers are empty.
module stx_buffer #(
    parameter int DEPTH = 4,
    parameter int W     = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         fifo_en,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic         avail,
    output logic [W-1:0] dout,
    output logic         txe,
    output logic         txfnf
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [W-1:0]     hold_q;
    logic             hold_v;
    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] rd_ptr, wr_ptr;
    logic [CNT_W-1:0] count;
    logic             full, do_push, do_pop;

    assign full    = (count == CNT_W'(DEPTH));
    assign do_push = push && fifo_en && !full;
    assign do_pop  = pop && fifo_en && (count != '0);

    // Single holding register
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            hold_v <= 1'b0;
            hold_q <= '0;
        end else begin
            if (pop && !fifo_en) hold_v <= 1'b0;
            if (push && !fifo_en) begin
                hold_q <= din;
                hold_v <= 1'b1;
            end
        end
    end

    // FIFO pointers and occupancy
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            count <= count + CNT_W'(do_push) - CNT_W'(do_pop);
        end
    end

    // FIFO storage, one register per entry
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) mem[g] <= '0;
            else if (do_push && wr_ptr == PTR_W'(g)) mem[g] <= din;
        end
    end

    // Output selection and flags for the active buffer
    always_comb begin
        if (fifo_en) begin
            avail = (count != '0);
            dout  = mem[rd_ptr];
            txe   = (count == '0);
            txfnf = !full;
        end else begin
            avail = hold_v;
            dout  = hold_q;
            txe   = !hold_v;
            txfnf = !hold_v;
        end
    end

    p_fifo_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));

    p_pop_nonempty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> avail);

    p_full_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_en && full && push && !pop && !flush) |=> full);

endmodule

// File: rtl/stx_framer.sv
// Builds the bit vector (first bit in bit 0) and length of the next frame
// from its kind, the data word and the configuration. Purely combinational.
module stx_framer
    import stx_pkg::*;
#(
    parameter int FRAME_W = STX_MAX_BITS + 4,
    parameter int CNT_W   = $clog2(FRAME_W + 1)
) (
    input  frame_kind_e              kind,
    input  logic [STX_MAX_BITS-1:0]  data,
    input  ctrl_t                    cfg,
    output logic [FRAME_W-1:0]       vec,
    output logic [CNT_W-1:0]         len
);

    int   nb, ns;
    logic par;

    // Frame assembly by kind
    always_comb begin
        nb  = data_bits(cfg.wlen);
        ns  = cfg.two_stop ? 2 : 1;
        vec = '1;
        par = cfg.par_odd;
        for (int i = 0; i < STX_MAX_BITS; i++) begin
            if (i < nb - 1) par = par ^ data[i];
        end
        case (kind)
            FK_DATA: begin
                vec[0] = 1'b0;
                for (int i = 0; i < STX_MAX_BITS; i++) begin
                    if (i < nb) vec[i+1] = (cfg.par_en && i == nb - 1) ? par : data[i];
                end
                len = CNT_W'(1 + nb + ns);
            end
            FK_IDLE: begin
                len = CNT_W'(1 + nb + ns);
            end
            default: begin
                for (int i = 0; i < STX_MAX_BITS + 2; i++) begin
                    if (i < nb + 2) vec[i] = 1'b0;
                end
                len = CNT_W'(nb + 4);
            end
        endcase
    end

endmodule

// File: rtl/stx_shifter.sv
// Output shift register. On each baud tick it emits the next bit of the
// current frame, loading a new frame first when load is high. Tracks
// whether the line is still occupied by the bit just emitted.
// Assumes load is only raised on a tick while the shifter is empty.
module stx_shifter #(
    parameter int FRAME_W = 13,
    parameter int CNT_W   = $clog2(FRAME_W + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               tick,
    input  logic               load,
    input  logic [FRAME_W-1:0] vec,
    input  logic [CNT_W-1:0]   len,
    output logic               txd,
    output logic               busy,
    output logic               empty
);

    logic [FRAME_W-1:0] sh_q, cur_sh;
    logic [CNT_W-1:0]   cnt_q, cur_cnt;

    // Frame source for this tick: fresh frame or remainder
    always_comb begin
        cur_sh  = load ? vec : sh_q;
        cur_cnt = load ? len : cnt_q;
    end

    assign empty = (cnt_q == '0);

    // Shift one bit onto the line per tick
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            sh_q  <= '0;
            cnt_q <= '0;
            txd   <= 1'b1;
            busy  <= 1'b0;
        end else if (tick) begin
            if (cur_cnt != '0) begin
                txd   <= cur_sh[0];
                sh_q  <= cur_sh >> 1;
                cnt_q <= cur_cnt - 1'b1;
                busy  <= 1'b1;
            end else begin
                txd   <= 1'b1;
                busy  <= 1'b0;
            end
        end
    end

    p_line_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !clear) |=> $stable(txd));

    p_load_when_empty_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> empty);

    p_quiet_line_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load && empty && !clear) |=> (txd && !busy));

endmodule

// File: rtl/serial_tx.sv
// Top of the serial transmitter. Decodes the write port, connects the
// control register, data buffer, framer and shifter, and derives the
// completion flag. Assumes baud_tick is a one-cycle pulse.
module serial_tx
    import stx_pkg::*;
#(
    parameter int FIFO_DEPTH = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       wr_sel,
    input  logic [8:0] wr_data,
    input  logic       baud_tick,
    output logic       txd,
    output logic       st_txe,
    output logic       st_txfnf,
    output logic       st_tc
);

    localparam int FRAME_W = STX_MAX_BITS + 4;
    localparam int CNT_W   = $clog2(FRAME_W + 1);

    ctrl_t                   wcfg, cfg;
    frame_kind_e             kind;
    logic                    wr_ctrl, wr_dat, flush, take, data_pop, have;
    logic                    pre_pend, brk_pend, avail, busy, sh_empty;
    logic [STX_MAX_BITS-1:0] buf_data;
    logic [FRAME_W-1:0]      vec;
    logic [CNT_W-1:0]        len;

    // Write decode and load decision
    always_comb begin
        wcfg     = ctrl_t'(wr_data);
        wr_ctrl  = wr_en && !wr_sel;
        wr_dat   = wr_en && wr_sel && cfg.ue;
        flush    = wr_ctrl && !wcfg.ue;
        have     = pre_pend || brk_pend || avail;
        take     = baud_tick && cfg.ue && cfg.te && sh_empty && have;
        data_pop = take && (kind == FK_DATA);
    end

    stx_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_ctrl  (wr_ctrl),
        .wcfg     (wcfg),
        .take     (take),
        .cfg      (cfg),
        .pre_pend (pre_pend),
        .brk_pend (brk_pend),
        .kind     (kind)
    );

    stx_buffer #(.DEPTH(FIFO_DEPTH), .W(STX_MAX_BITS)) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (flush),
        .fifo_en (cfg.fifo_en),
        .push    (wr_dat),
        .din     (wr_data),
        .pop     (data_pop),
        .avail   (avail),
        .dout    (buf_data),
        .txe     (st_txe),
        .txfnf   (st_txfnf)
    );

    stx_framer #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_framer (
        .kind (kind),
        .data (buf_data),
        .cfg  (cfg),
        .vec  (vec),
        .len  (len)
    );

    stx_shifter #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (flush),
        .tick  (baud_tick),
        .load  (take),
        .vec   (vec),
        .len   (len),
        .txd   (txd),
        .busy  (busy),
        .empty (sh_empty)
    );

    // Completion: line settled and nothing waiting
    assign st_tc = !busy && sh_empty && !pre_pend && !brk_pend && !avail;

    p_tc_line_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
        st_tc |-> txd);

    p_disable_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (st_tc && st_txe && txd));

endmodule

// File: tb/tb_serial_tx.sv
module tb_serial_tx;

    localparam int DEPTH = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_sel = 1'b0;
    logic [8:0] wr_data = '0;
    logic       baud_tick = 1'b0;
    logic       txd, st_txe, st_txfnf, st_tc;

    int  n_chk = 0;
    int  n_fail = 0;
    int  cyc = 0;
    bit  tick_rand = 1'b0;
    int  tcnt = 0;
    bit  done = 1'b0;

    // Reference model state
    bit  m_ue, m_te, m_two, m_pe, m_po, m_fe, m_pre, m_brk, m_busy, m_txd;
    bit [1:0] m_wl;
    int  m_dq[$];
    bit  m_line[$];

    serial_tx #(.FIFO_DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .baud_tick(baud_tick), .txd(txd),
        .st_txe(st_txe), .st_txfnf(st_txfnf), .st_tc(st_tc)
    );

    always #10 clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic int nbits(input bit [1:0] wl);
        if (wl == 2'b01) return 9;
        if (wl == 2'b10) return 7;
        return 8;
    endfunction

    // Append the bits of one frame to the model line: 0 idle, 1 break, 2 data
    task automatic m_frame(input int kind, input int d);
        int n, s;
        bit p;
        n = nbits(m_wl);
        s = m_two ? 2 : 1;
        if (kind == 0) begin
            repeat (1 + n + s) m_line.push_back(1'b1);
        end else if (kind == 1) begin
            repeat (n + 2) m_line.push_back(1'b0);
            repeat (2) m_line.push_back(1'b1);
        end else begin
            p = m_po;
            for (int i = 0; i < n - 1; i++) p ^= d[i];
            m_line.push_back(1'b0);
            for (int i = 0; i < n; i++)
                m_line.push_back((m_pe && i == n - 1) ? p : d[i]);
            repeat (s) m_line.push_back(1'b1);
        end
    endtask

    // Reference model, advanced on every rising edge
    always @(posedge clk) begin
        int sz0;
        bit [8:0] v;
        cyc++;
        if (!rst_n) begin
            {m_ue, m_te, m_two, m_pe, m_po, m_fe, m_pre, m_brk, m_busy} = '0;
            m_wl = 2'b00;
            m_txd = 1'b1;
            m_dq.delete();
            m_line.delete();
        end else begin
            sz0 = m_dq.size();
            if (baud_tick && m_ue) begin
                if (m_line.size() == 0 && m_te) begin
                    if (m_pre) begin
                        m_pre = 1'b0; m_frame(0, 0);
                    end else if (m_brk) begin
                        m_brk = 1'b0; m_frame(1, 0);
                    end else if (m_dq.size() != 0) begin
                        m_frame(2, m_dq.pop_front());
                    end
                end
                if (m_line.size() != 0) begin
                    m_txd = m_line.pop_front();
                    m_busy = 1'b1;
                end else begin
                    m_txd = 1'b1;
                    m_busy = 1'b0;
                end
            end
            if (wr_en && !wr_sel) begin
                v = wr_data;
                if (!v[0]) begin
                    m_pre = 0; m_brk = 0; m_busy = 0; m_txd = 1'b1;
                    m_dq.delete(); m_line.delete();
                end else begin
                    if (v[1] && !(m_ue && m_te)) m_pre = 1'b1;
                    if (v[8]) m_brk = 1'b1;
                end
                m_ue = v[0]; m_te = v[1]; m_wl = v[3:2]; m_two = v[4];
                m_pe = v[5]; m_po = v[6]; m_fe = v[7];
            end else if (wr_en && wr_sel && m_ue) begin
                if (m_fe) begin
                    if (sz0 < DEPTH) m_dq.push_back(int'(wr_data));
                end else begin
                    if (m_dq.size() != 0) m_dq[0] = int'(wr_data);
                    else m_dq.push_back(int'(wr_data));
                end
            end
        end
    end

    // Compare outputs against the model on every cycle
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R2 line", int'(txd), int'(m_txd));
            check("R6 st_txe", int'(st_txe), int'(m_dq.size() == 0));
            check("R7 st_txfnf", int'(st_txfnf),
                  int'(m_fe ? (m_dq.size() < DEPTH) : (m_dq.size() == 0)));
            check("R8 st_tc", int'(st_tc),
                  int'(!m_busy && m_line.size() == 0 && !m_pre && !m_brk && m_dq.size() == 0));
        end
    end

    // Baud tick generator
    always @(negedge clk) begin
        if (tick_rand) begin
            baud_tick = ($urandom_range(0, 2) == 0);
        end else begin
            tcnt = (tcnt + 1) % 4;
            baud_tick = (tcnt == 0);
        end
    end

    task automatic finish_run();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    endtask

    // Watchdog
    always @(posedge clk) begin
        if (cyc > 150000) begin
            n_fail++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            finish_run();
        end
    end

    task automatic wr(input bit sel, input int v);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = v[8:0];
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Capture n bit periods starting at the next start bit (4-cycle ticks)
    task automatic grab(input int n, output int bits, output int start_cyc);
        int lim;
        lim = 0;
        bits = 0;
        while (txd !== 1'b0 && lim < 400) begin
            @(negedge clk); lim++;
        end
        start_cyc = cyc;
        for (int k = 0; k < n; k++) begin
            bits |= int'(txd) << k;
            repeat (4) @(negedge clk);
        end
    endtask

    task automatic wait_tc();
        int lim;
        lim = 0;
        while (st_tc !== 1'b1 && lim < 1000) begin
            @(negedge clk); lim++;
        end
        check("R8 completion reached", int'(st_tc), 1);
    endtask

    initial begin
        int g, t0, t1, lows;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 txd", int'(txd), 1);
        check("R1 st_txe", int'(st_txe), 1);
        check("R1 st_txfnf", int'(st_txfnf), 1);
        check("R1 st_tc", int'(st_tc), 1);

        // R4 preamble then R2 8N1 character 0xA5
        wr(0, 9'h003);
        t0 = cyc;
        wr(1, 9'h0A5);
        check("R6 st_txe after data write", int'(st_txe), 0);
        grab(10, g, t1);
        check("R4 preamble length in cycles", int'((t1 - t0) >= 40 && (t1 - t0) <= 48), 1);
        check("R2 frame 0xA5 8N1", g, 'h34A);
        wait_tc();
        check("R10 idle line", int'(txd), 1);

        // R3 even parity, 7 bits, 2 stops, data 0x0B
        wr(0, 9'h03B);
        wr(1, 9'h00B);
        grab(10, g, t1);
        check("R3 even parity 7E2 frame", g, 'h396);
        wait_tc();

        // R3 odd parity, 9 bits, 1 stop, data 0x070
        wr(0, 9'h067);
        wr(1, 9'h070);
        grab(11, g, t1);
        check("R3 odd parity 9-bit frame", g, 'h4E0);
        wait_tc();

        // R5 break ahead of pending data (te off while queuing)
        wr(0, 9'h001);
        wr(1, 9'h0C3);
        wr(0, 9'h101);
        check("R9 no frame while te clear", int'(txd), 1);
        wr(0, 9'h003);
        grab(13, g, t1);
        check("R5 break 10 low then 2 high then data start", g, 'hC00);
        wait_tc();

        // R7 FIFO: fill with te clear, fifth write dropped
        wr(0, 9'h081);
        for (int k = 1; k <= 5; k++) begin
            wr(1, k * 'h11);
            if (k == 4) begin
                check("R7 st_txfnf low when full", int'(st_txfnf), 0);
                check("R7 st_txe low in FIFO mode", int'(st_txe), 0);
            end
        end
        repeat (20) @(negedge clk);
        check("R9 line idle with te clear", int'(txd), 1);
        wr(0, 9'h083);
        for (int k = 1; k <= 4; k++) begin
            grab(10, g, t1);
            check("R7 FIFO order", g, ((k * 'h11) << 1) | 'h200);
        end
        lows = 0;
        for (int k = 0; k < 60; k++) begin
            @(negedge clk);
            if (txd === 1'b0) lows++;
        end
        check("R7 dropped write not sent", lows, 0);
        check("R8 st_tc after FIFO drain", int'(st_tc), 1);

        // R9 disable mid-frame
        wr(0, 9'h003);
        wr(1, 9'h000);
        grab(1, g, t1);
        repeat (4) @(negedge clk);
        wr(0, 9'h000);
        check("R9 line high after disable", int'(txd), 1);
        check("R9 st_tc after disable", int'(st_tc), 1);
        check("R9 st_txe after disable", int'(st_txe), 1);
        wr(1, 9'h055);
        check("R9 data write ignored while off", int'(st_txe), 1);
        wr(0, 9'h003);
        wait_tc();

        // Random traffic against the model
        tick_rand = 1'b1;
        for (int it = 0; it < 3000; it++) begin
            int r, v;
            r = $urandom_range(0, 7);
            if (r < 3) begin
                wr(1, $urandom_range(0, 511));
            end else if (r == 3) begin
                v = $urandom_range(0, 511);
                v[0] = ($urandom_range(0, 15) != 0);
                if (m_dq.size() != 0) v[7] = m_fe;
                wr(0, v);
            end else begin
                repeat ($urandom_range(1, 6)) @(negedge clk);
            end
        end
        tick_rand = 1'b0;
        wr(0, 9'h003);
        wait_tc();
        repeat (10) @(negedge clk);
        finish_run();
    end

endmodule